// File: doc/BRIEF.md
# Serial CRC-8 Frame Checker

This block sits beside the receive path of a single-wire sensor bus controller and checks, one bit per strobe, whether a received frame arrived intact. A frame is either a 56-bit device identifier or a 64-bit scratchpad image, in both cases followed by the 8-bit CRC the sensor sent. Bits arrive least significant bit first. The checker runs a reflected bit-serial CRC over them with the generator x^8 + x^5 + x^4 + 1. After the last CRC bit it reports a one-cycle done pulse. The match flag rises in that same cycle when the register ends at zero.

A start strobe opens a frame and captures the frame kind. A synchronous clear drops everything back to idle. The checker never holds up the bus transaction. The controlling logic reads `done_o`/`match_o` and decides what to do next. The running remainder is visible at all times on `rem_o`. After only the body bits it equals the CRC the sender should append.

Top module: `crc8_frame_chk`

## Requirements
- R1: After reset, `rem_o` is 0x00 and `done_o` and `match_o` are low.
- R2: Each accepted bit b updates the remainder r as f = r[0]^b, r' = (r>>1) ^ (f ? 0x8C : 0x00). Starting from zero and fed a frame body LSB first, byte by byte, `rem_o` then equals that body's CRC.
- R3: `start_i` zeroes the remainder and the bit count, opens a frame and captures `mode_i`. A later change of `mode_i` inside the frame has no effect. A start strobe in the middle of a frame restarts it.
- R4: With `mode_i`=0 (identifier) the frame is 56 body bits plus 8 CRC bits; no done pulse appears before the 64th accepted bit.
- R5: With `mode_i`=1 (scratchpad) the frame is 64 body bits plus 8 CRC bits; no done pulse appears before the 72nd accepted bit.
- R6: `done_o` is high for exactly one cycle, in the cycle after the edge that accepts the frame's last bit.
- R7: `match_o` is high only together with `done_o`, and only when the remainder after the last CRC bit is 0x00. A single flipped bit anywhere in the frame gives a done pulse with `match_o` low.
- R8: A bit is accepted only when `bit_vld_i` is high and a frame is open. Bits offered while idle or after a frame closes leave `rem_o` unchanged.
- R9: `clr_i` takes priority over `start_i` and `bit_vld_i`. It zeroes the remainder, drops `done_o`/`match_o` and returns to idle, and no frame is opened in that cycle.
- R10: When `start_i` and `bit_vld_i` are high in the same cycle, that bit is the first bit of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to idle |
| start_i | input | 1 | Opens a new frame and captures the mode |
| mode_i | input | 1 | Frame kind: 0 identifier (56-bit body), 1 scratchpad (64-bit body) |
| bit_vld_i | input | 1 | Strobe: `bit_i` carries a frame bit this cycle |
| bit_i | input | 1 | Serial data bit, LSB first |
| rem_o | output | 8 | Running CRC remainder |
| done_o | output | 1 | One-cycle pulse after the frame's last bit |
| match_o | output | 1 | With `done_o`: remainder ended at zero |

## Verification
The hardest situations to reach from the ports are the ones where control strobes collide with data. These are a start strobe that carries the frame's first bit, a restart or clear in the middle of a frame, and a `mode_i` change while a frame is open. Directed sequences drive exactly those overlaps and then finish a known-good identifier frame, so a mishandled collision shows up as a missing or wrong match. Randomly drawn scratchpad frames, some with a corrupted CRC byte, cover the data path. Expected remainders come from a byte-wise CRC function in the bench.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W    = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;  // x^8+x^5+x^4+1, reflected
  localparam int ID_BODY  = 56;
  localparam int SCR_BODY = 64;
  localparam int ID_LEN   = ID_BODY + CRC_W;
  localparam int SCR_LEN  = SCR_BODY + CRC_W;
  localparam int MAX_LEN  = (ID_LEN > SCR_LEN) ? ID_LEN : SCR_LEN;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  typedef enum logic {
    FRM_ID  = 1'b0,
    FRM_SCR = 1'b1
  } frm_mode_e;

  function automatic logic [CNT_W-1:0] frame_len(frm_mode_e m);
    return (m == FRM_SCR) ? CNT_W'(SCR_LEN) : CNT_W'(ID_LEN);
  endfunction
endpackage

// File: rtl/crc8_step.sv
module crc8_step #(
  parameter int                W    = 8,
  parameter logic [W-1:0]      POLY = 8'h8C
) (
  input  logic [W-1:0] crc_i,
  input  logic         din_i,
  output logic [W-1:0] crc_o
);
  logic fb;
  assign fb = crc_i[0] ^ din_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W-1) begin : g_top
      assign crc_o[i] = fb & POLY[i];
    end else begin : g_mid
      assign crc_o[i] = crc_i[i+1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc8_bit_cnt.sv
module crc8_bit_cnt
  import crc8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, base;

  assign base   = clear_i ? '0 : cnt_q;
  assign last_o = step_i && (base == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : base + CNT_W'(1);
    else              cnt_q <= base;
  end

  // R4/R5: count never reaches a full frame without wrapping
  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_LEN));
endmodule

// File: rtl/crc8_frame_chk.sv
module crc8_frame_chk
  import crc8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] rem_o,
  output logic             done_o,
  output logic             match_o
);
  logic [CRC_W-1:0] crc_q, crc_base, crc_nxt;
  logic             open_q, done_q, match_q, take, last;
  frm_mode_e        mode_q, mode_eff;
  logic             restart;

  assign restart  = start_i & ~clr_i;
  assign mode_eff = restart ? frm_mode_e'(mode_i) : mode_q;
  assign take     = bit_vld_i & ~clr_i & (start_i | open_q);
  assign crc_base = restart ? '0 : crc_q;

  crc8_step #(.W(CRC_W), .POLY(POLY_REFL)) u_step (
    .crc_i (crc_base),
    .din_i (bit_i),
    .crc_o (crc_nxt)
  );

  crc8_bit_cnt u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clr_i | start_i),
    .step_i  (take),
    .len_i   (frame_len(mode_eff)),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q   <= '0;
      open_q  <= 1'b0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      mode_q  <= FRM_ID;
    end else if (clr_i) begin
      crc_q   <= '0;
      open_q  <= 1'b0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      done_q  <= take & last;
      match_q <= take & last & (crc_nxt == '0);
      mode_q  <= mode_eff;
      if (take)         crc_q <= crc_nxt;
      else if (restart) crc_q <= '0;
      if (take & last)  open_q <= 1'b0;
      else if (restart) open_q <= 1'b1;
    end
  end

  assign rem_o   = crc_q;
  assign done_o  = done_q;
  assign match_o = match_q;

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_match_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> done_o);
  assert_match_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (rem_o == '0));
  assert_clr_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rem_o == '0) && !done_o && !open_q);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !start_i && !clr_i) |=> $stable(rem_o));
  assert_done_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !open_q || $past(start_i));
endmodule

// File: tb/crc8_frame_chk_tb.sv
module crc8_frame_chk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, start = 1'b0, mode = 1'b0, vld = 1'b0, din = 1'b0;
  logic [7:0] rem;
  logic       done, match;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  crc8_frame_chk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .start_i(start), .mode_i(mode),
    .bit_vld_i(vld), .bit_i(din), .rem_o(rem), .done_o(done), .match_o(match)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] b [8], input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c ^= b[i];
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic b, input logic c);
    @(negedge clk);
    start = s; vld = v; din = b; clr = c;
    @(posedge clk); #1;
    start = 1'b0; vld = 1'b0; clr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) drive(1'b0, 1'b1, b[k], 1'b0);
  endtask

  logic [7:0] id_v [8] = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00, 8'hA2};

  // Sends an identifier frame from an already opened state; returns done/match
  task automatic id_body_and_crc(input int skip_first, output logic d, output logic m);
    for (int i = 0; i < 8; i++)
      for (int k = (i == 0) ? skip_first : 0; k < 8; k++) drive(1'b0, 1'b1, id_v[i][k], 1'b0);
    d = done; m = match;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic       d, m;
    logic [7:0] sp [8];
    logic [7:0] c, hold;
    void'($urandom(32'd7581));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rem", rem, 8'h00);
    chk("R1 done", {7'd0, done}, 8'h00);
    chk("R1 match", {7'd0, match}, 8'h00);
    rst_n = 1'b1;

    // R8 bits offered while idle are ignored
    send_byte(8'hFF);
    chk("R8 idle bits ignored", rem, 8'h00);

    // R2/R4 known identifier frame, checked bit by bit
    chk("R2 reference crc of id body", ref_crc(id_v, 7), 8'hA2);
    mode = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) send_byte(id_v[i]);
    chk("R2 remainder after id body", rem, 8'hA2);
    // R8 idle strobe inside an open frame changes nothing
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R8 no strobe no change", rem, 8'hA2);
    for (int k = 0; k < 7; k++) drive(1'b0, 1'b1, id_v[7][k], 1'b0);
    chk("R4 no done before bit 64", {7'd0, done}, 8'h00);
    drive(1'b0, 1'b1, id_v[7][7], 1'b0);
    chk("R4 done after bit 64", {7'd0, done}, 8'h01);
    chk("R7 match good id", {7'd0, match}, 8'h01);
    chk("R7 remainder zero", rem, 8'h00);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 done single cycle", {7'd0, done}, 8'h00);
    chk("R6 match single cycle", {7'd0, match}, 8'h00);

    // R7 single-bit error
    id_v[3] ^= 8'h10;
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    id_body_and_crc(0, d, m);
    chk("R7 bit error done", {7'd0, d}, 8'h01);
    chk("R7 bit error no match", {7'd0, m}, 8'h00);
    id_v[3] ^= 8'h10;
    hold = rem;
    chk("R7 bit error nonzero rem", {7'd0, (hold != 8'h00)}, 8'h01);
    // R8 bits after the frame closed are ignored
    send_byte(8'h5A);
    chk("R8 closed frame ignores bits", rem, hold);
    chk("R8 no second done", {7'd0, done}, 8'h00);

    // R10 start carries first bit; R3 mode change mid-frame ignored
    mode = 1'b0;
    drive(1'b1, 1'b1, id_v[0][0], 1'b0);
    mode = 1'b1;
    id_body_and_crc(1, d, m);
    chk("R10 start with first bit, done", {7'd0, d}, 8'h01);
    chk("R3 mode held, match at 64 bits", {7'd0, m}, 8'h01);
    mode = 1'b0;

    // R3 restart mid-frame
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    send_byte(8'h3C); send_byte(8'hE1);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 restart zeroes rem", rem, 8'h00);
    id_body_and_crc(0, d, m);
    chk("R3 restart then good frame", {7'd0, m}, 8'h01);

    // R9 clear mid-frame, and clear beating start
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    send_byte(8'hA7);
    drive(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R9 clear zeroes rem", rem, 8'h00);
    send_byte(8'hFF);
    chk("R9 idle after clear", rem, 8'h00);
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    send_byte(8'hFF);
    chk("R9 clear beats start", rem, 8'h00);

    // R5/R2/R7 random scratchpad frames
    for (int f = 0; f < 24; f++) begin
      for (int i = 0; i < 8; i++) sp[i] = 8'($urandom);
      c = ref_crc(sp, 8);
      mode = 1'b1;
      drive(1'b1, 1'b0, 1'b0, 1'b0);
      mode = 1'($urandom);  // must not matter once opened
      for (int i = 0; i < 8; i++) send_byte(sp[i]);
      chk("R2 scratchpad body remainder", rem, c);
      chk("R5 no done at bit 64", {7'd0, done}, 8'h00);
      if (f % 3 == 2) c ^= 8'(1 << (f % 8));
      send_byte(c);
      chk("R5 done at bit 72", {7'd0, done}, 8'h01);
      chk("R7 scratchpad match", {7'd0, match}, (f % 3 == 2) ? 8'h00 : 8'h01);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule